// File: doc/BRIEF.md
# Complementary PWM Pair Generator with Centred Dead Gap

This unit drives a bank of PWM channel outputs. Any two distinct channels can be bound into a pair that runs from a single shared period counter. The first channel of a pair is high at the start of each period. The second channel pulses inside the first channel's low time. Its pulse is placed so that equal dead gaps sit on both sides of it. Each gap is half of the period left over after both high times, rounded down.

A pair is configured with one transfer on a valid/ready configuration port. The transfer carries:
- the slot index;
- the two channel numbers;
- the period P;
- the two high times A and B.

The unit checks the transfer in the same cycle. A bad configuration is dropped and flagged on `cfg_err`, and the active settings stay as they were. Start and stop are plain per-slot pulses. Both channels of a slot change state on the same clock edge, so the pair never drifts out of phase.

The unit never applies back-pressure. `cfg_ready` is tied high, and a transfer takes place on every cycle in which `cfg_valid` is high. A source may therefore present a new configuration every cycle.

Top module: `pwm_cpair_unit`

## Requirements
- R1: With dead gap G = (P − A − B) >> 1, the second channel is high exactly in period cycles c with A+G ≤ c < A+G+B, and low otherwise.
- R2: The first channel is high in period cycles 0 ≤ c < A and low for the rest of each period. The period counts cycles 0 to P−1 and then wraps to 0.
- R3: A transfer with A + B greater than P is rejected. A + B equal to P is accepted and gives a zero dead gap.
- R4: A transfer with A equal to 0 or B equal to 0 is rejected.
- R5: A transfer is rejected if it names the same channel twice, a channel number of NCH or more, or a slot number of NPAIR or more.
- R6: A transfer is rejected if either of its channels is owned by a configured slot other than its own. A slot may be reconfigured with the channels it already owns.
- R7: A rejected transfer raises `cfg_err` in the cycle after the transfer only, and `cfg_err` is low in the following cycle. The slot's timing and channels are left as they were.
- R8: A start pulse on a configured slot resets both channel phases to cycle 0 on the same edge. The first channel is high in the next cycle. A start while the slot is running restarts the period.
- R9: A stop pulse drives both channels of the slot low from the next cycle on. Stop takes priority over a start in the same cycle.
- R10: An accepted transfer to a slot takes effect on the next edge and restarts that slot's period at cycle 0. Whether the slot is running does not change.
- R11: A start on a slot that holds no accepted configuration has no effect. Channels that are not part of a configured pair stay low.
- R12: After reset all outputs and `cfg_err` are low, no slot is configured, and `cfg_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Configuration transfer present |
| cfg_ready | output | 1 | Always high; no back-pressure |
| cfg_slot | input | SW | Pair slot being configured |
| cfg_ch_a | input | CHW | Channel that leads high |
| cfg_ch_b | input | CHW | Channel with the centred pulse |
| cfg_period | input | CW | Period P in cycles |
| cfg_high_a | input | CW | High time A of the first channel |
| cfg_high_b | input | CW | High time B of the second channel |
| start | input | NPAIR | Per-slot start pulse |
| stop | input | NPAIR | Per-slot stop pulse |
| cfg_err | output | 1 | One-cycle reject flag |
| pwm_out | output | NCH | PWM channel outputs |

## Verification
The bench targets the arithmetic corners of the gap.

- **Odd leftover.** The leftover period is odd (P=9, A=2, B=2). A design that rounded the halving up, or did not halve, would shift or clip the second pulse.
- **Zero gap.** A + B equals P exactly. A design that used `>=` instead of `>` in the sum test would reject this valid setting.
- **Rejected transfers.** Every reject reason is tried in turn. A design with loose ownership or range checks would hijack a channel already used by another slot. After the rejects, a restart of the slot shows whether the old timing survived.
- **Reload, resync and collision.** The bench reloads a slot while it runs, resyncs a slot that is running, and applies start and stop together. A design with the wrong priority, or one that missed the counter clear, would show a phase-shifted or still-running waveform.

// File: rtl/cpair_pkg.sv
package cpair_pkg;
  typedef enum logic [2:0] {
    CK_OK,
    CK_SLOT,
    CK_CHAN,
    CK_ZERO,
    CK_SUM,
    CK_OWNED
  } cfg_verdict_e;
endpackage

// File: rtl/cpair_cfg_check.sv
module cpair_cfg_check
  import cpair_pkg::*;
#(
  parameter int NCH   = 6,
  parameter int NPAIR = 2,
  parameter int CW    = 16,
  parameter int CHW   = 3,
  parameter int SW    = 1
) (
  input  logic [SW-1:0]              slot,
  input  logic [CHW-1:0]             ch_a,
  input  logic [CHW-1:0]             ch_b,
  input  logic [CW-1:0]              period,
  input  logic [CW-1:0]              high_a,
  input  logic [CW-1:0]              high_b,
  input  logic [NPAIR-1:0]           owned,
  input  logic [NPAIR-1:0][CHW-1:0]  own_a,
  input  logic [NPAIR-1:0][CHW-1:0]  own_b,
  output cfg_verdict_e               verdict
);
  logic [CW:0] sum_w;
  logic        clash;

  assign sum_w = {1'b0, high_a} + {1'b0, high_b};

  always_comb begin
    clash = 1'b0;
    for (int s = 0; s < NPAIR; s++) begin
      if (owned[s] && (slot != SW'(s)) &&
          (own_a[s] == ch_a || own_a[s] == ch_b ||
           own_b[s] == ch_a || own_b[s] == ch_b))
        clash = 1'b1;
    end
  end

  always_comb begin
    if ({1'b0, slot} >= (SW+1)'(NPAIR))
      verdict = CK_SLOT;
    else if (ch_a == ch_b || {1'b0, ch_a} >= (CHW+1)'(NCH) ||
             {1'b0, ch_b} >= (CHW+1)'(NCH))
      verdict = CK_CHAN;
    else if (high_a == '0 || high_b == '0)
      verdict = CK_ZERO;
    else if (sum_w > {1'b0, period})
      verdict = CK_SUM;
    else if (clash)
      verdict = CK_OWNED;
    else
      verdict = CK_OK;
  end
endmodule

// File: rtl/cpair_engine.sv
module cpair_engine #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          start,
  input  logic          stop,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] high_a,
  input  logic [CW-1:0] high_b,
  output logic          out_a,
  output logic          out_b
);
  logic [CW-1:0] per_q, fall_a_q, rise_b_q, fall_b_q, cnt_q;
  logic          run_q;
  logic [CW-1:0] slack, gap;

  assign slack = period - high_a - high_b;
  assign gap   = slack >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q    <= '0;
      fall_a_q <= '0;
      rise_b_q <= '0;
      fall_b_q <= '0;
    end else if (load) begin
      per_q    <= period;
      fall_a_q <= high_a;
      rise_b_q <= high_a + gap;
      fall_b_q <= high_a + gap + high_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (stop)       run_q <= 1'b0;
      else if (start) run_q <= 1'b1;
      if (start || load)
        cnt_q <= '0;
      else if (run_q)
        cnt_q <= (cnt_q == per_q - CW'(1)) ? '0 : cnt_q + CW'(1);
    end
  end

  assign out_a = run_q && (cnt_q < fall_a_q);
  assign out_b = run_q && (cnt_q >= rise_b_q) && (cnt_q < fall_b_q);
endmodule

// File: rtl/pwm_cpair_unit.sv
module pwm_cpair_unit
  import cpair_pkg::*;
#(
  parameter int NCH   = 6,
  parameter int NPAIR = 2,
  parameter int CW    = 16,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int SW   = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  output logic             cfg_ready,
  input  logic [SW-1:0]    cfg_slot,
  input  logic [CHW-1:0]   cfg_ch_a,
  input  logic [CHW-1:0]   cfg_ch_b,
  input  logic [CW-1:0]    cfg_period,
  input  logic [CW-1:0]    cfg_high_a,
  input  logic [CW-1:0]    cfg_high_b,
  input  logic [NPAIR-1:0] start,
  input  logic [NPAIR-1:0] stop,
  output logic             cfg_err,
  output logic [NCH-1:0]   pwm_out
);
  cfg_verdict_e             verdict;
  logic                     accept;
  logic [NPAIR-1:0]         slot_vld;
  logic [NPAIR-1:0][CHW-1:0] own_a, own_b;
  logic [NPAIR-1:0]         eng_a, eng_b;

  assign cfg_ready = 1'b1;

  cpair_cfg_check #(
    .NCH(NCH), .NPAIR(NPAIR), .CW(CW), .CHW(CHW), .SW(SW)
  ) i_check (
    .slot(cfg_slot), .ch_a(cfg_ch_a), .ch_b(cfg_ch_b),
    .period(cfg_period), .high_a(cfg_high_a), .high_b(cfg_high_b),
    .owned(slot_vld), .own_a(own_a), .own_b(own_b),
    .verdict(verdict)
  );

  assign accept = cfg_valid && (verdict == CK_OK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_err <= 1'b0;
    else        cfg_err <= cfg_valid && (verdict != CK_OK);
  end

  for (genvar s = 0; s < NPAIR; s++) begin : g_slot
    logic load_s;
    assign load_s = accept && (cfg_slot == SW'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_vld[s] <= 1'b0;
        own_a[s]    <= '0;
        own_b[s]    <= '0;
      end else if (load_s) begin
        slot_vld[s] <= 1'b1;
        own_a[s]    <= cfg_ch_a;
        own_b[s]    <= cfg_ch_b;
      end
    end

    cpair_engine #(.CW(CW)) i_engine (
      .clk(clk), .rst_n(rst_n),
      .load(load_s),
      .start(start[s] && slot_vld[s]),
      .stop(stop[s]),
      .period(cfg_period), .high_a(cfg_high_a), .high_b(cfg_high_b),
      .out_a(eng_a[s]), .out_b(eng_b[s])
    );
  end

  always_comb begin
    pwm_out = '0;
    for (int c = 0; c < NCH; c++) begin
      for (int s = 0; s < NPAIR; s++) begin
        if (slot_vld[s] && own_a[s] == CHW'(c)) pwm_out[c] = pwm_out[c] | eng_a[s];
        if (slot_vld[s] && own_b[s] == CHW'(c)) pwm_out[c] = pwm_out[c] | eng_b[s];
      end
    end
  end
endmodule

// File: rtl/pwm_cpair_chk.sv
module pwm_cpair_chk #(
  parameter int NPAIR = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_valid,
  input logic             cfg_err,
  input logic [NPAIR-1:0] start,
  input logic [NPAIR-1:0] stop,
  input logic [NPAIR-1:0] slot_vld,
  input logic [NPAIR-1:0] eng_a,
  input logic [NPAIR-1:0] eng_b
);
  // R7
  err_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $past(cfg_valid));

  for (genvar s = 0; s < NPAIR; s++) begin : g_s
    // R1
    dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(eng_a[s] && eng_b[s]));
    // R9
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop[s] |=> (!eng_a[s] && !eng_b[s]));
    // R8
    start_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start[s] && !stop[s] && slot_vld[s]) |=> eng_a[s]);
    // R11
    idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_vld[s] |-> (!eng_a[s] && !eng_b[s]));
  end
endmodule

bind pwm_cpair_unit pwm_cpair_chk #(.NPAIR(NPAIR)) i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_err(cfg_err),
  .start(start), .stop(stop), .slot_vld(slot_vld),
  .eng_a(eng_a), .eng_b(eng_b)
);

// File: tb/test_pwm_cpair_unit.sv
module test_pwm_cpair_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic        cfg_ready;
  logic [0:0]  cfg_slot = '0;
  logic [2:0]  cfg_ch_a = '0, cfg_ch_b = '0;
  logic [15:0] cfg_period = '0, cfg_high_a = '0, cfg_high_b = '0;
  logic [1:0]  start = '0, stop = '0;
  logic        cfg_err;
  logic [5:0]  pwm_out;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pwm_cpair_unit i_pwm_cpair_unit (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_slot(cfg_slot), .cfg_ch_a(cfg_ch_a), .cfg_ch_b(cfg_ch_b),
    .cfg_period(cfg_period), .cfg_high_a(cfg_high_a), .cfg_high_b(cfg_high_b),
    .start(start), .stop(stop), .cfg_err(cfg_err), .pwm_out(pwm_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Transfer at a negedge; returns at the negedge after the accepting edge.
  task automatic cfg(input int slot, input int a, input int b, input int p,
                     input int ha, input int hb, input int exp_err, input string req);
    cfg_slot = 1'(slot); cfg_ch_a = 3'(a); cfg_ch_b = 3'(b);
    cfg_period = 16'(p); cfg_high_a = 16'(ha); cfg_high_b = 16'(hb);
    cfg_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_valid = 1'b0;
    chk(req, int'(cfg_err), exp_err);
  endtask

  task automatic pulse(input logic [1:0] st, input logic [1:0] sp);
    start = st; stop = sp;
    @(posedge clk);
    @(negedge clk);
    start = '0; stop = '0;
  endtask

  // Samples from the current negedge, which is period cycle 0.
  task automatic wave(input int ca, input int cb, input int p, input int ha,
                      input int hb, input int n, input string req_a, input string req_b);
    int g;
    g = (p - ha - hb) / 2;
    for (int k = 0; k < n; k++) begin
      int ph;
      ph = k % p;
      chk(req_a, int'(pwm_out[ca]), (ph < ha) ? 1 : 0);
      chk(req_b, int'(pwm_out[cb]), (ph >= ha + g && ph < ha + g + hb) ? 1 : 0);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R12 pwm_out", int'(pwm_out), 0);
    chk("R12 cfg_err", int'(cfg_err), 0);
    chk("R12 cfg_ready", int'(cfg_ready), 1);
  endtask

  task automatic t_idle_start();
    pulse(2'b01, 2'b00);
    chk("R11 unconfigured start", int'(pwm_out), 0);
    @(negedge clk);
    chk("R11 unconfigured start", int'(pwm_out), 0);
  endtask

  task automatic t_basic();
    cfg(0, 0, 1, 10, 3, 4, 0, "R2 accept");
    chk("R11 stopped after cfg", int'(pwm_out), 0);
    pulse(2'b01, 2'b00);
    wave(0, 1, 10, 3, 4, 25, "R2", "R1");
  endtask

  task automatic t_odd_gap();
    cfg(1, 2, 3, 9, 2, 2, 0, "R1 accept");
    pulse(2'b10, 2'b00);
    wave(2, 3, 9, 2, 2, 20, "R2 odd", "R1 odd");
    chk("R11 unpaired low", int'(pwm_out[5:4]), 0);
  endtask

  task automatic t_reload();
    cfg(1, 2, 3, 6, 2, 4, 0, "R6 own reuse");
    wave(2, 3, 6, 2, 4, 14, "R10", "R3 zero gap");
  endtask

  task automatic t_reject();
    cfg(1, 2, 3, 5, 3, 3, 1, "R3 sum");        @(negedge clk); chk("R7 one cycle", int'(cfg_err), 0);
    cfg(1, 2, 3, 8, 0, 3, 1, "R4 zero a");     @(negedge clk); chk("R7 one cycle", int'(cfg_err), 0);
    cfg(1, 2, 3, 8, 3, 0, 1, "R4 zero b");     @(negedge clk); chk("R7 one cycle", int'(cfg_err), 0);
    cfg(1, 4, 4, 8, 2, 2, 1, "R5 same chan");  @(negedge clk); chk("R7 one cycle", int'(cfg_err), 0);
    cfg(1, 6, 2, 8, 2, 2, 1, "R5 range");      @(negedge clk); chk("R7 one cycle", int'(cfg_err), 0);
    cfg(1, 2, 0, 8, 2, 2, 1, "R6 owned");      @(negedge clk); chk("R7 one cycle", int'(cfg_err), 0);
    cfg(1, 1, 0, 8, 2, 2, 1, "R6 both owned"); @(negedge clk); chk("R7 one cycle", int'(cfg_err), 0);
    pulse(2'b10, 2'b00);
    wave(2, 3, 6, 2, 4, 12, "R7 kept a", "R7 kept b");
  endtask

  task automatic t_resync();
    repeat (3) @(negedge clk);
    pulse(2'b01, 2'b00);
    wave(0, 1, 10, 3, 4, 12, "R8 resync", "R8 resync");
  endtask

  task automatic t_stop();
    pulse(2'b10, 2'b11);
    for (int k = 0; k < 5; k++) begin
      chk("R9 stop wins", int'(pwm_out), 0);
      @(negedge clk);
    end
    pulse(2'b01, 2'b00);
    chk("R8 restart after stop", int'(pwm_out[0]), 1);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL R12 watchdog: actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_start();
    t_basic();
    t_odd_gap();
    t_reload();
    t_reject();
    t_resync();
    t_stop();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule